// File: doc/BRIEF.md
# Flash Sector Write-Protection Checker

This block sits in front of the embedded program and erase engine of a 4 M-word uniform-sector flash array. Each program, sector erase or multi-sector erase request is judged against three sources of protection, and the block answers with a one-cycle permit or refuse pulse. The three sources are a per-sector lock bit, an active-low write-protect pin that pins one boundary sector (the lowest or highest, chosen by a configuration input), and a one-way lock on a separate 128-word secured region. An accelerate-mode flag lifts the lock bits for the duration of the mode, but it never lifts the pin or the secured-region lock.

The block owns the lock-bit register. A set command locks one sector, and a clear command unlocks every sector at once while leaving the secured-region lock as it is. The secured region can be locked but never unlocked by any command. For multi-sector erase, the block returns the subset of the requested sectors that may be erased. A combinational status bit reports the protection seen by an identification read of the addressed sector. That bit combines the lock bit and the pin override and ignores accelerate mode.

Top module: `flash_guard`

## Requirements
- R1: After reset, `grant`, `deny` and `erase_en` are zero, `sec_locked` is 0, and all lock bits are clear, so `stat_prot` is 0 for any sector while `wp_n` is high.
- R2: With `accel` low and `wp_n` high, a program (`req_op`=1) or sector erase (`req_op`=2) on an array sector (`req_secure`=0, sector index `req_addr[21:15]`) is granted if the sector's lock bit is clear and is denied if it is set.
- R3: While `wp_n` is low, the boundary sector (index 0 when `wp_top`=0, index 127 when `wp_top`=1) is protected whatever its lock bit or `accel`. No other sector is affected by the pin.
- R4: While `wp_n` is high, the boundary sector is protected exactly when its own lock bit is set.
- R5: While `accel` is high, lock bits are ignored for array requests, but the pin-protected boundary sector stays denied.
- R6: `sec_lock_cmd` sets `sec_locked`. The lock can never be cleared (including by `lk_clr_all`), and once it is set every request with `req_secure`=1 is denied, even in accelerate mode.
- R7: With the secured region unlocked, a secured request is granted only when `req_addr` is below 128. A secured request at address 128 or above is denied.
- R8: `lk_clr_all` clears all 128 lock bits. When `lk_clr_all` and `lk_set` occur in the same cycle, the clear wins.
- R9: A multi-sector erase (`req_op`=3, `req_secure`=0) drives `erase_en` to `req_mask` with every protected sector removed, and raises `grant` if that set is non-empty. If the set is empty, it raises `deny` and `erase_en` stays zero. `erase_en` is non-zero only together with `grant`.
- R10: Each request with `req_op` non-zero gives exactly one of `grant` or `deny`, high for the single cycle after the request cycle. `req_op`=0 gives neither.
- R11: `stat_prot` is, at once, the OR of the lock bit and the pin override for the sector `req_addr[21:15]`, independent of `accel`.
- R12: A request is judged against the lock state held before any lock command issued in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_op | input | 2 | 0 none, 1 program, 2 sector erase, 3 multi-sector erase |
| req_secure | input | 1 | Request targets the secured region |
| req_addr | input | 22 | Word address; also selects the sector for `stat_prot` |
| req_mask | input | 128 | Sectors selected for a multi-sector erase |
| wp_n | input | 1 | Write-protect pin, active low |
| accel | input | 1 | Accelerate mode active |
| wp_top | input | 1 | Pin protects sector 127 (1) or sector 0 (0) |
| lk_set | input | 1 | Set the lock bit of sector `lk_sect` |
| lk_sect | input | 7 | Sector index for `lk_set` |
| lk_clr_all | input | 1 | Clear all lock bits |
| sec_lock_cmd | input | 1 | Lock the secured region permanently |
| grant | output | 1 | Request permitted (one-cycle pulse) |
| deny | output | 1 | Request refused (one-cycle pulse) |
| erase_en | output | 128 | Sectors to erase, valid with `grant` |
| stat_prot | output | 1 | Protection status of the addressed sector |
| sec_locked | output | 1 | Secured region is locked |

## Verification
Two functions can fall in the same cycle: a lock command and a request on the same sector, and a clear-all together with a set. The bench issues `lk_set` on a sector in the same cycle as a program there and expects a grant, then repeats the program alone and expects a refusal. It also pairs `lk_set` with `lk_clr_all` and expects the named sector to come out unlocked. A clear-all after the secured lock is judged by a secured request that must still be refused.

// File: rtl/fg_pkg.sv
package fg_pkg;
   typedef enum logic [1:0] {
      OP_NONE   = 2'd0,
      OP_PROG   = 2'd1,
      OP_SERASE = 2'd2,
      OP_MERASE = 2'd3
   } fg_op_e;
endpackage

// File: rtl/fg_lock_bank.sv
// Holds the per-sector lock bits and the one-way secured-region lock.
module fg_lock_bank #(
   parameter int SECT_W   = 7,
   localparam int NUM_SECT = 1 << SECT_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                set_i,
   input  logic [SECT_W-1:0]   sect_i,
   input  logic                clr_all_i,
   input  logic                sec_lock_i,
   output logic [NUM_SECT-1:0] lock_o,
   output logic                sec_locked_o
);
   logic [NUM_SECT-1:0] lock_q;
   logic                sec_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lock_q <= '0;
      end else if (clr_all_i) begin
         lock_q <= '0;
      end else if (set_i) begin
         lock_q[sect_i] <= 1'b1;
      end
   end

   // Only ever rises; no command path lowers it.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sec_q <= 1'b0;
      end else if (sec_lock_i) begin
         sec_q <= 1'b1;
      end
   end

   assign lock_o       = lock_q;
   assign sec_locked_o = sec_q;
endmodule

// File: rtl/fg_prot_eval.sv
// Per-sector effective protection (for writes) and status protection (for reads).
module fg_prot_eval #(
   parameter int SECT_W   = 7,
   localparam int NUM_SECT = 1 << SECT_W
) (
   input  logic [NUM_SECT-1:0] lock_i,
   input  logic                wp_n_i,
   input  logic                accel_i,
   input  logic                wp_top_i,
   output logic [NUM_SECT-1:0] wr_prot_o,
   output logic [NUM_SECT-1:0] st_prot_o
);
   logic [SECT_W-1:0] bnd_idx;
   assign bnd_idx = wp_top_i ? SECT_W'(NUM_SECT - 1) : '0;

   for (genvar i = 0; i < NUM_SECT; i++) begin : g_sect
      logic pin_force;
      assign pin_force    = !wp_n_i && (bnd_idx == SECT_W'(i));
      assign wr_prot_o[i] = pin_force | (lock_i[i] & ~accel_i);
      assign st_prot_o[i] = pin_force | lock_i[i];
   end
endmodule

// File: rtl/fg_decider.sv
// Registers one permit/refuse decision per request.
module fg_decider
   import fg_pkg::*;
#(
   parameter int ADDR_W   = 22,
   parameter int SECT_W   = 7,
   parameter int SEC_AW   = 7,
   localparam int NUM_SECT = 1 << SECT_W
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  fg_op_e                   op_i,
   input  logic                     secure_i,
   input  logic [ADDR_W-1:SEC_AW]   addr_hi_i,
   input  logic [SECT_W-1:0]        sect_i,
   input  logic [NUM_SECT-1:0]      mask_i,
   input  logic [NUM_SECT-1:0]      wr_prot_i,
   input  logic                     sec_locked_i,
   output logic                     grant_o,
   output logic                     deny_o,
   output logic [NUM_SECT-1:0]      erase_en_o
);
   logic                ok;
   logic [NUM_SECT-1:0] sel;

   always_comb begin
      sel = '0;
      ok  = 1'b0;
      if (secure_i) begin
         ok = !sec_locked_i && (addr_hi_i == '0);
      end else if (op_i == OP_MERASE) begin
         sel = mask_i & ~wr_prot_i;
         ok  = |sel;
      end else begin
         ok = !wr_prot_i[sect_i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         grant_o    <= 1'b0;
         deny_o     <= 1'b0;
         erase_en_o <= '0;
      end else if (op_i == OP_NONE) begin
         grant_o    <= 1'b0;
         deny_o     <= 1'b0;
         erase_en_o <= '0;
      end else begin
         grant_o    <= ok;
         deny_o     <= !ok;
         erase_en_o <= ok ? sel : '0;
      end
   end
endmodule

// File: rtl/flash_guard.sv
module flash_guard
   import fg_pkg::*;
#(
   parameter int ADDR_W    = 22,
   parameter int SECT_W    = 7,
   parameter int SEC_WORDS = 128,
   localparam int NUM_SECT = 1 << SECT_W,
   localparam int SEC_AW   = $clog2(SEC_WORDS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [1:0]          req_op,
   input  logic                req_secure,
   input  logic [ADDR_W-1:0]   req_addr,
   input  logic [NUM_SECT-1:0] req_mask,
   input  logic                wp_n,
   input  logic                accel,
   input  logic                wp_top,
   input  logic                lk_set,
   input  logic [SECT_W-1:0]   lk_sect,
   input  logic                lk_clr_all,
   input  logic                sec_lock_cmd,
   output logic                grant,
   output logic                deny,
   output logic [NUM_SECT-1:0] erase_en,
   output logic                stat_prot,
   output logic                sec_locked
);
   if (ADDR_W <= SECT_W) begin : g_bad_addr
      $error("ADDR_W must exceed SECT_W");
   end
   if ((1 << SEC_AW) != SEC_WORDS || SEC_AW >= ADDR_W) begin : g_bad_sec
      $error("SEC_WORDS must be a power of two that fits the address");
   end

   logic [NUM_SECT-1:0] lock_q;
   logic [NUM_SECT-1:0] wr_prot;
   logic [NUM_SECT-1:0] st_prot;
   logic [SECT_W-1:0]   sect;

   assign sect = req_addr[ADDR_W-1 -: SECT_W];

   fg_lock_bank #(.SECT_W(SECT_W)) u_bank (
      .clk          (clk),
      .rst_n        (rst_n),
      .set_i        (lk_set),
      .sect_i       (lk_sect),
      .clr_all_i    (lk_clr_all),
      .sec_lock_i   (sec_lock_cmd),
      .lock_o       (lock_q),
      .sec_locked_o (sec_locked)
   );

   fg_prot_eval #(.SECT_W(SECT_W)) u_eval (
      .lock_i    (lock_q),
      .wp_n_i    (wp_n),
      .accel_i   (accel),
      .wp_top_i  (wp_top),
      .wr_prot_o (wr_prot),
      .st_prot_o (st_prot)
   );

   fg_decider #(.ADDR_W(ADDR_W), .SECT_W(SECT_W), .SEC_AW(SEC_AW)) u_dec (
      .clk          (clk),
      .rst_n        (rst_n),
      .op_i         (fg_op_e'(req_op)),
      .secure_i     (req_secure),
      .addr_hi_i    (req_addr[ADDR_W-1:SEC_AW]),
      .sect_i       (sect),
      .mask_i       (req_mask),
      .wr_prot_i    (wr_prot),
      .sec_locked_i (sec_locked),
      .grant_o      (grant),
      .deny_o       (deny),
      .erase_en_o   (erase_en)
   );

   assign stat_prot = st_prot[sect];
endmodule

// File: rtl/fg_checker.sv
module fg_checker #(
   parameter int SECT_W   = 7,
   localparam int NUM_SECT = 1 << SECT_W
) (
   input logic                clk,
   input logic                rst_n,
   input logic [1:0]          req_op,
   input logic                req_secure,
   input logic [SECT_W-1:0]   sect,
   input logic                wp_n,
   input logic                wp_top,
   input logic                lk_clr_all,
   input logic                grant,
   input logic                deny,
   input logic [NUM_SECT-1:0] erase_en,
   input logic                sec_locked,
   input logic [NUM_SECT-1:0] lock_q
);
   logic single_op;
   logic at_bnd;
   assign single_op = (req_op == 2'd1) || (req_op == 2'd2);
   assign at_bnd    = wp_top ? (sect == SECT_W'(NUM_SECT - 1)) : (sect == '0);

   assert_one_answer_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(grant && deny));
   assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_op == 2'd0) |=> (!grant && !deny));
   assert_busy_answer_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_op != 2'd0) |=> (grant || deny));
   assert_pin_boundary_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (single_op && !req_secure && !wp_n && at_bnd) |=> deny);
   assert_sec_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      sec_locked |=> sec_locked);
   assert_sec_refuse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_locked && req_secure && req_op != 2'd0) |=> deny);
   assert_erase_with_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (erase_en != '0) |-> grant);
   assert_clear_all_R8: assert property (@(posedge clk) disable iff (!rst_n)
      lk_clr_all |=> (lock_q == '0));
endmodule

bind flash_guard fg_checker #(.SECT_W(SECT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_op     (req_op),
   .req_secure (req_secure),
   .sect       (sect),
   .wp_n       (wp_n),
   .wp_top     (wp_top),
   .lk_clr_all (lk_clr_all),
   .grant      (grant),
   .deny       (deny),
   .erase_en   (erase_en),
   .sec_locked (sec_locked),
   .lock_q     (lock_q)
);

// File: tb/flash_guard_bench.sv
`timescale 1ns/1ps
module flash_guard_bench;
   localparam int NS = 128;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    req_op = '0;
   logic          req_secure = 1'b0;
   logic [21:0]   req_addr = '0;
   logic [NS-1:0] req_mask = '0;
   logic          wp_n = 1'b1;
   logic          accel = 1'b0;
   logic          wp_top = 1'b0;
   logic          lk_set = 1'b0;
   logic [6:0]    lk_sect = '0;
   logic          lk_clr_all = 1'b0;
   logic          sec_lock_cmd = 1'b0;
   logic          grant, deny, stat_prot, sec_locked;
   logic [NS-1:0] erase_en;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   flash_guard u_flash_guard (
      .clk(clk), .rst_n(rst_n), .req_op(req_op), .req_secure(req_secure),
      .req_addr(req_addr), .req_mask(req_mask), .wp_n(wp_n), .accel(accel),
      .wp_top(wp_top), .lk_set(lk_set), .lk_sect(lk_sect), .lk_clr_all(lk_clr_all),
      .sec_lock_cmd(sec_lock_cmd), .grant(grant), .deny(deny), .erase_en(erase_en),
      .stat_prot(stat_prot), .sec_locked(sec_locked)
   );

   // row: {wp_n, accel, wp_top, op[1:0], sector[6:0], expect_grant}
   // locked sectors during the walk: 0, 5, 127
   localparam logic [12:0] VEC [12] = '{
      {1'b1, 1'b0, 1'b0, 2'd1, 7'd3,   1'b1},
      {1'b1, 1'b0, 1'b0, 2'd1, 7'd5,   1'b0},
      {1'b1, 1'b0, 1'b0, 2'd2, 7'd0,   1'b0},
      {1'b1, 1'b0, 1'b1, 2'd1, 7'd127, 1'b0},
      {1'b0, 1'b1, 1'b0, 2'd1, 7'd0,   1'b0},
      {1'b0, 1'b1, 1'b1, 2'd1, 7'd0,   1'b1},
      {1'b0, 1'b1, 1'b1, 2'd2, 7'd127, 1'b0},
      {1'b1, 1'b1, 1'b0, 2'd1, 7'd127, 1'b1},
      {1'b0, 1'b0, 1'b0, 2'd1, 7'd1,   1'b1},
      {1'b0, 1'b1, 1'b0, 2'd2, 7'd5,   1'b1},
      {1'b0, 1'b0, 1'b1, 2'd1, 7'd126, 1'b1},
      {1'b1, 1'b1, 1'b0, 2'd2, 7'd0,   1'b1}
   };

   task automatic check(input string tag, input logic [NS-1:0] act, input logic [NS-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [21:0] sa(input int s);
      return 22'(s) << 15;
   endfunction

   // Drive a request at negedge, sample the answer one edge later at the next negedge.
   task automatic req(input logic [1:0] op, input logic sec, input logic [21:0] a,
                      input logic [NS-1:0] m);
      req_op = op; req_secure = sec; req_addr = a; req_mask = m;
      @(negedge clk);
      req_op = 2'd0; req_secure = 1'b0; req_mask = '0;
   endtask

   task automatic lock_one(input int s);
      lk_set = 1'b1; lk_sect = 7'(s);
      @(negedge clk);
      lk_set = 1'b0;
   endtask

   task automatic clear_all();
      lk_clr_all = 1'b1;
      @(negedge clk);
      lk_clr_all = 1'b0;
   endtask

   initial begin
      repeat (400000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [NS-1:0] m;
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 grant", NS'(grant), '0);
      check("R1 deny", NS'(deny), '0);
      check("R1 erase_en", erase_en, '0);
      check("R1 sec_locked", NS'(sec_locked), '0);
      rst_n = 1'b1;
      @(negedge clk);
      req_addr = sa(0);
      #1 check("R1 stat_prot", NS'(stat_prot), '0);

      lock_one(0); lock_one(5); lock_one(127);

      // Table walk: R2 R3 R4 R5
      for (int i = 0; i < 12; i++) begin
         logic [12:0] v;
         v = VEC[i];
         wp_n = v[12]; accel = v[11]; wp_top = v[10];
         req(v[9:8], 1'b0, sa(int'(v[7:1])), '0);
         check($sformatf("R2 R3 R4 R5 row %0d grant", i), NS'(grant), NS'(v[0]));
         check($sformatf("R10 row %0d deny", i), NS'(deny), NS'(!v[0]));
         @(negedge clk);
         check($sformatf("R10 row %0d pulse ends", i), NS'({grant, deny}), '0);
      end

      // R11 status ignores accel, includes pin
      wp_n = 1'b1; accel = 1'b1; wp_top = 1'b0; req_addr = sa(5);
      #1 check("R11 locked under accel", NS'(stat_prot), 1);
      req_addr = sa(3);
      #1 check("R11 unlocked", NS'(stat_prot), 0);
      wp_n = 1'b0; wp_top = 1'b1; req_addr = sa(126);
      #1 check("R11 not boundary", NS'(stat_prot), 0);
      accel = 1'b0;
      @(negedge clk);

      // R9 multi-sector erase: locks 0,5,127, pin on 127
      m = '0; m[2] = 1'b1; m[5] = 1'b1; m[127] = 1'b1;
      req(2'd3, 1'b0, '0, m);
      m = '0; m[2] = 1'b1;
      check("R9 subset", erase_en, m);
      check("R9 grant", NS'(grant), 1);
      m = '0; m[5] = 1'b1; m[127] = 1'b1;
      req(2'd3, 1'b0, '0, m);
      check("R9 empty erase_en", erase_en, '0);
      check("R9 empty deny", NS'(deny), 1);
      wp_n = 1'b1;
      req(2'd3, 1'b0, '0, '1);
      m = '1; m[0] = 1'b0; m[5] = 1'b0; m[127] = 1'b0;
      check("R9 chip erase", erase_en, m);

      // R12 same-cycle set and request
      lk_set = 1'b1; lk_sect = 7'd9;
      req(2'd1, 1'b0, sa(9), '0);
      lk_set = 1'b0;
      check("R12 old state used", NS'(grant), 1);
      req(2'd1, 1'b0, sa(9), '0);
      check("R12 new lock applies", NS'(deny), 1);

      // R8 clear wins over set; clear unlocks all
      lk_set = 1'b1; lk_sect = 7'd10; lk_clr_all = 1'b1;
      @(negedge clk);
      lk_set = 1'b0; lk_clr_all = 1'b0;
      req(2'd1, 1'b0, sa(10), '0);
      check("R8 clear beats set", NS'(grant), 1);
      req(2'd2, 1'b0, sa(5), '0);
      check("R8 sector 5 cleared", NS'(grant), 1);
      req(2'd1, 1'b0, sa(127), '0);
      check("R8 sector 127 cleared", NS'(grant), 1);

      // R7 secured range
      req(2'd1, 1'b1, 22'd100, '0);
      check("R7 in range", NS'(grant), 1);
      req(2'd1, 1'b1, 22'd128, '0);
      check("R7 out of range", NS'(deny), 1);

      // R6 one-way secured lock
      sec_lock_cmd = 1'b1;
      @(negedge clk);
      sec_lock_cmd = 1'b0;
      check("R6 locked flag", NS'(sec_locked), 1);
      req(2'd1, 1'b1, 22'd5, '0);
      check("R6 refuse", NS'(deny), 1);
      clear_all();
      accel = 1'b1;
      req(2'd2, 1'b1, 22'd5, '0);
      check("R6 survives clear and accel", NS'(deny), 1);
      check("R6 still locked", NS'(sec_locked), 1);
      accel = 1'b0;
      req(2'd1, 1'b0, sa(3), '0);
      check("R6 array unaffected", NS'(grant), 1);

      // R10 idle cycle
      req(2'd0, 1'b0, sa(3), '0);
      check("R10 idle", NS'({grant, deny}), '0);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule